// File: doc/BRIEF.md
# Two-Class Level Interrupt Steering Controller

This block gathers 32 level-sensitive interrupt request lines from peripherals, masks each one with a per-source enable bit, and steers every source to one of two processor interrupt classes. The two classes are a fast class and a normal class. A per-source class-select bit makes the choice. The block drives one fast-class output and one normal-class output toward the processor.

Software reaches the block through a small register bus:

| Offset | Register | Access |
|---|---|---|
| 0x0 | raw request status | read-only |
| 0x4 | enable | read/write |
| 0x8 | class select | read/write |
| 0xC | normal-class status | read-only |
| 0x10 | fast-class status | read-only |

The controller keeps no pending state and has no clear operation. A request is dropped only when software clears the condition inside the peripheral that raised it.

Request lines are brought into the clock domain through a two-flop synchronizer. The two class outputs are registered. The register bus is plain control access. Every write takes effect on the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. The bus has no stall and no back-pressure, so no valid/ready handshake is needed.

Top module: `dual_class_intc`

## Requirements
- R1: After reset, the enable and select registers read 0x00000000. The raw status, fast-class status and normal-class status registers read 0x00000000. Both `fiq_o` and `irq_o` are low.
- R2: A write to offset 0x4 replaces all 32 enable bits at once, with bit n enabling source n. Writing 0x0000000A enables only sources 1 and 3, and the value reads back at 0x4.
- R3: A write to offset 0x8 replaces all 32 select bits, and the value reads back at 0x8. A select bit of 1 assigns source n to the fast class; a 0 assigns it to the normal class.
- R4: Offset 0x0 reads the synchronized request lines, one bit per source, whatever the enable setting. A request change becomes visible there after the second rising clock edge and not after the first.
- R5: Offset 0x10 reads request AND enable AND select. Offset 0xC reads request AND enable AND NOT select.
- R6: A disabled source that asserts its request causes no change on `fiq_o` or `irq_o` and sets no bit in either class status register.
- R7: `fiq_o` is the OR of the fast-class status bits and `irq_o` is the OR of the normal-class status bits. Each output updates one clock edge after its status value changes, so an output follows a request change on the third rising edge.
- R8: Writes to the read-only offsets 0x0, 0xC and 0x10 leave the enable and select registers unchanged. A read of any unmapped offset returns 0x00000000.
- R9: Requests are not latched. When a request line falls, its status bits clear and the class output falls, with the same latencies as when the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Level-sensitive peripheral requests, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| fiq_o | output | 1 | Fast-class interrupt to the processor |
| irq_o | output | 1 | Normal-class interrupt to the processor |

## Verification
Corrupt enable or select flops show up at once on the readback offsets. They also show up in the class status registers in the same cycle, and on `fiq_o`/`irq_o` one edge later, as a source in the wrong class or a masked source that leaks through. A synchronizer with the wrong depth moves the raw status by a whole cycle, and the bench samples that between edges. A wrong output register shows as an output that lags its status view by a cycle other than one, or as an output that sticks after the request is released.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_NORM = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_FAST = 5'h10;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      sel_q
);
  logic wr_en, wr_sel;
  assign wr_en  = bus_wr && (bus_addr == OFS_EN);
  assign wr_sel = bus_wr && (bus_addr == OFS_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr_en)  en_q  <= bus_wdata;
      if (wr_sel) sel_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/intc_steer.sv
module intc_steer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_sync,
  input  logic [W-1:0] en_q,
  input  logic [W-1:0] sel_q,
  output logic [W-1:0] fast_vec,
  output logic [W-1:0] norm_vec,
  output logic         fast_o,
  output logic         norm_o
);
  logic [W-1:0] live;
  assign live     = req_sync & en_q;
  assign fast_vec = live & sel_q;
  assign norm_vec = live & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_o <= 1'b0;
      norm_o <= 1'b0;
    end else begin
      fast_o <= |fast_vec;
      norm_o <= |norm_vec;
    end
  end
endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  req_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_SRC-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0]  bus_rdata,
  output logic                fiq_o,
  output logic                irq_o
);
  logic [NUM_SRC-1:0] req_sync, en_q, sel_q, fast_vec, norm_vec;

  intc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(req_i), .dout(req_sync)
  );

  intc_regs #(.W(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .sel_q(sel_q)
  );

  intc_steer #(.W(NUM_SRC)) u_steer (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .en_q(en_q), .sel_q(sel_q),
    .fast_vec(fast_vec), .norm_vec(norm_vec), .fast_o(fiq_o), .norm_o(irq_o)
  );

  always_comb begin
    case (bus_addr)
      OFS_RAW:  bus_rdata = req_sync;
      OFS_EN:   bus_rdata = en_q;
      OFS_SEL:  bus_rdata = sel_q;
      OFS_NORM: bus_rdata = norm_vec;
      OFS_FAST: bus_rdata = fast_vec;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      req_sync,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      sel_q,
  input logic [W-1:0]      fast_vec,
  input logic [W-1:0]      norm_vec,
  input logic              fiq_o,
  input logic              irq_o
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (en_q == '0 && sel_q == '0 && !fiq_o && !irq_o)); // R1

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN) |=> (en_q == $past(bus_wdata))); // R2

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SEL) |=> (sel_q == $past(bus_wdata))); // R3

  AST_CLASS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    ((fast_vec & norm_vec) == '0)); // R5

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (((fast_vec | norm_vec) & ~(req_sync & en_q)) == '0)); // R6

  AST_FIQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|fast_vec))); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|norm_vec))); // R7

  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_RAW || bus_addr == OFS_NORM || bus_addr == OFS_FAST))
    |=> ($stable(en_q) && $stable(sel_q))); // R8
endmodule

bind dual_class_intc intc_checker #(.W(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .req_sync(req_sync), .en_q(en_q), .sel_q(sel_q),
  .fast_vec(fast_vec), .norm_vec(norm_vec), .fiq_o(fiq_o), .irq_o(irq_o)
);

// File: tb/dual_class_intc_tb.sv
module dual_class_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_class_intc u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  // req, enable, select, fast view, normal view, fiq, irq
  typedef struct packed {
    logic [31:0] req;
    logic [31:0] en;
    logic [31:0] sel;
    logic [31:0] fast;
    logic [31:0] norm;
    logic        f;
    logic        n;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{32'h0000000A, 32'h0000000A, 32'h00000000, 32'h00000000, 32'h0000000A, 1'b0, 1'b1},
    '{32'h0000000A, 32'h0000000A, 32'h00000002, 32'h00000002, 32'h00000008, 1'b1, 1'b1},
    '{32'h80000001, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'h00000001, 1'b1, 1'b1},
    '{32'h0000FF00, 32'h00F0F000, 32'hFFFFFFFF, 32'h0000F000, 32'h00000000, 1'b1, 1'b0},
    '{32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h04, d); chk("R1 enable", d, 32'h0);
    rd(5'h08, d); chk("R1 select", d, 32'h0);
    rd(5'h00, d); chk("R1 raw status", d, 32'h0);
    rd(5'h0C, d); chk("R1 normal status", d, 32'h0);
    rd(5'h10, d); chk("R1 fast status", d, 32'h0);
    chk("R1 outputs", {30'd0, fiq_o, irq_o}, 32'h0);

    // table walk: R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(5'h04, VECS[i].en);
      wr(5'h08, VECS[i].sel);
      req_i = VECS[i].req;
      repeat (4) @(negedge clk);
      rd(5'h00, d); chk("R4 raw status", d, VECS[i].req);
      rd(5'h10, d); chk("R5 fast status", d, VECS[i].fast);
      rd(5'h0C, d); chk("R5 normal status", d, VECS[i].norm);
      chk("R7 fiq_o", {31'd0, fiq_o}, {31'd0, VECS[i].f});
      chk("R7 irq_o", {31'd0, irq_o}, {31'd0, VECS[i].n});
      if (i == 0) chk("R6 masked outputs", {30'd0, fiq_o, irq_o}, 32'h0);
    end

    // R2 whole-word enable replace
    wr(5'h04, 32'hFFFF0000);
    wr(5'h04, 32'h0000000A);
    rd(5'h04, d); chk("R2 enable readback", d, 32'h0000000A);
    // R3 select readback
    wr(5'h08, 32'h5A5A00FF);
    rd(5'h08, d); chk("R3 select readback", d, 32'h5A5A00FF);

    // R8 writes to read-only offsets ignored
    wr(5'h00, 32'hFFFFFFFF);
    wr(5'h0C, 32'hFFFFFFFF);
    wr(5'h10, 32'h12345678);
    rd(5'h04, d); chk("R8 enable kept", d, 32'h0000000A);
    rd(5'h08, d); chk("R8 select kept", d, 32'h5A5A00FF);
    rd(5'h14, d); chk("R8 unmapped read", d, 32'h0);
    rd(5'h1C, d); chk("R8 unmapped read high", d, 32'h0);

    // R4 R7 R9 latency: source 3 enabled, normal class
    wr(5'h08, 32'h0);
    req_i = 32'h0;
    repeat (4) @(negedge clk);
    req_i = 32'h00000008;
    @(negedge clk);
    rd(5'h00, d); chk("R4 raw after one edge", d, 32'h0);
    @(negedge clk);
    rd(5'h00, d); chk("R4 raw after two edges", d, 32'h00000008);
    rd(5'h0C, d); chk("R5 normal after two edges", d, 32'h00000008);
    chk("R7 irq_o before third edge", {31'd0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R7 irq_o after third edge", {31'd0, irq_o}, 32'h1);
    chk("R7 fiq_o stays low", {31'd0, fiq_o}, 32'h0);
    req_i = 32'h0;
    @(negedge clk);
    chk("R9 irq_o held one edge", {31'd0, irq_o}, 32'h1);
    @(negedge clk);
    rd(5'h0C, d); chk("R9 normal status cleared", d, 32'h0);
    @(negedge clk);
    chk("R9 irq_o released", {31'd0, irq_o}, 32'h0);

    // R6 disabled source 0 asserted, no effect
    req_i = 32'h00000001;
    repeat (4) @(negedge clk);
    rd(5'h00, d); chk("R6 raw shows request", d, 32'h1);
    rd(5'h0C, d); chk("R6 normal view empty", d, 32'h0);
    rd(5'h10, d); chk("R6 fast view empty", d, 32'h0);
    chk("R6 outputs low", {30'd0, fiq_o, irq_o}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule